// File: doc/BRIEF.md
# DMA Window Address Translator

This block sits on the inbound side of an I/O bridge. It turns addresses issued by bus-master devices into physical memory addresses. Four programmable windows each claim a range of the bus address space. A window either passes the offset inside the range straight through (direct mode) or uses the page part of that offset to index a page table in memory (scatter-gather mode). Table entries are fetched over a simple read interface and kept in a small fully associative translation cache.

Software programs each window through a register write port. Every window has a base word, a mask word and a table-base word. A separate write flushes the whole translation cache, and software issues it both before and after changing windows. Lookups enter on a valid/ready request channel and leave on a valid/ready response channel. Each response carries the physical address, an error code and a flag that tells whether a table read was needed.

The control is a five-state sequencer:
- `ST_IDLE` accepts a request and always moves to `ST_MATCH`.
- `ST_MATCH` resolves the window and the cache. On no hit, a direct window or a cache hit it moves to `ST_RESP`. On a scatter-gather cache miss it moves to `ST_FETCH`.
- `ST_FETCH` issues one table read and always moves to `ST_WAIT`.
- `ST_WAIT` waits for the read data and then moves to `ST_RESP`.
- `ST_RESP` holds the response until it is taken, then returns to `ST_IDLE`.

Top module: `dwt_translator`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `tbl_req` are 0. The windows come up as follows:
  - window 0: scatter-gather, 8 MB at 0x0080_0000, table base 0x10_0000_0000;
  - window 1: direct, 1 GB at 0x8000_0000;
  - window 2: scatter-gather, 1 GB at 0xC000_0000, table base 0x20_0000_0000;
  - window 3: disabled.
- R2: Register writes use `reg_kind` 0 for the base word, 1 for the mask word and 2 for the table-base word of window `reg_win`. In the base word, bit 0 is the enable bit, bit 1 selects scatter-gather, and bits 31:20 hold the window address. In the mask word, bits 31:20 hold the size minus one. A window hits when it is enabled and `addr[31:20] & ~mask[31:20]` equals `base[31:20]`. A disabled window never hits.
- R3: When several windows hit, the lowest-numbered window translates the address.
- R4: An address that hits no window responds with `rsp_err` = 1, `rsp_paddr` = 0 and no table read.
- R5: A direct window responds with `rsp_err` = 0 and `rsp_paddr` = `addr & {mask[31:20], 20'hFFFFF}`, zero-extended, with no table read.
- R6: On a scatter-gather cache miss, one table read is issued at `tbase + 8*(offset >> 13)`, where offset is the masked address from R5. With valid data the response is `{pte[27:1], addr[12:0]}` with `rsp_err` = 0. PTE bits above 27 are ignored.
- R7: A PTE with bit 0 clear responds with `rsp_err` = 2 and `rsp_paddr` = 0. Such an entry is not cached, so a repeat lookup reads the table again.
- R8: A repeated lookup to the same window and 8 KB page hits the cache. It gives the same frame, with `rsp_walked` = 0. `rsp_walked` is 1 exactly when the response needed a table read.
- R9: The cache holds 8 entries that are replaced in round-robin order. The ninth distinct fill evicts the first.
- R10: A write with `reg_kind` = 3 invalidates every cached translation.
- R11: An invalidate that arrives while a table read is outstanding still lets that response through, but the fetched entry is not cached.
- R12: While `rsp_valid` is high and `rsp_ready` is low, the response stays stable and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_win | input | 2 | Target window |
| reg_kind | input | 2 | 0 base, 1 mask, 2 table base, 3 invalidate all |
| reg_wdata | input | 40 | Write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_paddr | output | 40 | Physical address |
| rsp_err | output | 2 | 0 ok, 1 no window, 2 invalid PTE |
| rsp_walked | output | 1 | Response needed a table read |
| tbl_req | output | 1 | One-cycle table read strobe |
| tbl_addr | output | 40 | Table entry address |
| tbl_rvalid | input | 1 | Table read data valid |
| tbl_rdata | input | 64 | Page table entry |

## Verification
The main sweep sends one address per 1 MB granule across the whole 4 GB bus space, with a varying offset inside each granule. It runs against the reset windows, so it separates the no-hit, direct and scatter-gather paths and their exact boundaries. The table model marks one page slot in 32 as invalid, so the same sweep exercises error responses. Directed sequences then separate a cache hit from a refetch: repeated pages, nine distinct pages for round-robin eviction, a flush, and a flush in the middle of a read. Reprogramming then disables a window, overlaps two windows to expose priority, and moves a table base.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MATCH,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } dwt_state_e;

    localparam logic [1:0] ERR_OK     = 2'd0;
    localparam logic [1:0] ERR_NOHIT  = 2'd1;
    localparam logic [1:0] ERR_BADPTE = 2'd2;

    localparam logic [1:0] KIND_BASE  = 2'd0;
    localparam logic [1:0] KIND_MASK  = 2'd1;
    localparam logic [1:0] KIND_TBASE = 2'd2;
    localparam logic [1:0] KIND_FLUSH = 2'd3;

    localparam int EN_BIT = 0;
    localparam int SG_BIT = 1;

    // Reset window image for 32-bit bus addresses and 40-bit physical addresses
    localparam logic [127:0] RST_BASE  = {32'h0000_0000, 32'hC000_0003,
                                          32'h8000_0001, 32'h0080_0003};
    localparam logic [127:0] RST_MASK  = {32'h0000_0000, 32'h3FF0_0000,
                                          32'h3FF0_0000, 32'h0070_0000};
    localparam logic [159:0] RST_TBASE = {40'h00_0000_0000, 40'h20_0000_0000,
                                          40'h00_0000_0000, 40'h10_0000_0000};

endpackage

// File: rtl/dwt_regs.sv
module dwt_regs
    import dwt_pkg::*;
#(
    parameter int NWIN    = 4,
    parameter int ADDR_W  = 32,
    parameter int PA_W    = 40,
    parameter int WIN_LSB = 20,
    parameter logic [NWIN*ADDR_W-1:0] DEF_BASE  = '0,
    parameter logic [NWIN*ADDR_W-1:0] DEF_MASK  = '0,
    parameter logic [NWIN*PA_W-1:0]   DEF_TBASE = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [$clog2(NWIN)-1:0]           win,
    input  logic [1:0]                        kind,
    input  logic [PA_W-1:0]                   wdata,
    output logic [NWIN-1:0][ADDR_W-1:0]       base_o,
    output logic [NWIN-1:0][ADDR_W-1:0]       mask_o,
    output logic [NWIN-1:0][PA_W-1:0]         tbase_o,
    output logic                              flush_o
);

    localparam logic [ADDR_W-1:0] BASE_KEEP =
        {{(ADDR_W-WIN_LSB){1'b1}}, {(WIN_LSB-2){1'b0}}, 2'b11};
    localparam logic [ADDR_W-1:0] MASK_KEEP =
        {{(ADDR_W-WIN_LSB){1'b1}}, {WIN_LSB{1'b0}}};

    assign flush_o = we && (kind == KIND_FLUSH);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic sel;
        assign sel = we && (win == w[$clog2(NWIN)-1:0]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_o[w]  <= DEF_BASE[w*ADDR_W +: ADDR_W] & BASE_KEEP;
                mask_o[w]  <= DEF_MASK[w*ADDR_W +: ADDR_W] & MASK_KEEP;
                tbase_o[w] <= DEF_TBASE[w*PA_W +: PA_W];
            end else if (sel) begin
                unique case (kind)
                    KIND_BASE:  base_o[w]  <= wdata[ADDR_W-1:0] & BASE_KEEP;
                    KIND_MASK:  mask_o[w]  <= wdata[ADDR_W-1:0] & MASK_KEEP;
                    KIND_TBASE: tbase_o[w] <= wdata;
                    default:    ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dwt_decode.sv
module dwt_decode
    import dwt_pkg::*;
#(
    parameter int NWIN    = 4,
    parameter int ADDR_W  = 32,
    parameter int PA_W    = 40,
    parameter int WIN_LSB = 20
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [NWIN-1:0][ADDR_W-1:0]       base,
    input  logic [NWIN-1:0][ADDR_W-1:0]       mask,
    input  logic [NWIN-1:0][PA_W-1:0]         tbase,
    output logic                              hit,
    output logic [$clog2(NWIN)-1:0]           win,
    output logic                              sg,
    output logic [ADDR_W-1:0]                 offset,
    output logic [PA_W-1:0]                   tbase_sel
);

    localparam int HI_W = ADDR_W - WIN_LSB;

    logic [NWIN-1:0]             hit_vec;
    logic [NWIN-1:0][ADDR_W-1:0] off_vec;

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        logic [HI_W-1:0] hi_mask;
        assign hi_mask    = mask[w][ADDR_W-1:WIN_LSB];
        assign hit_vec[w] = base[w][EN_BIT] &&
            ((addr[ADDR_W-1:WIN_LSB] & ~hi_mask) == base[w][ADDR_W-1:WIN_LSB]);
        assign off_vec[w] = addr & {hi_mask, {WIN_LSB{1'b1}}};
    end

    // Lowest index wins: scan from the top so lower windows overwrite
    always_comb begin
        hit       = 1'b0;
        win       = '0;
        sg        = 1'b0;
        offset    = '0;
        tbase_sel = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit       = 1'b1;
                win       = w[$clog2(NWIN)-1:0];
                sg        = base[w][SG_BIT];
                offset    = off_vec[w];
                tbase_sel = tbase[w];
            end
        end
    end

endmodule

// File: rtl/dwt_tlb.sv
module dwt_tlb #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 21,
    parameter int PFN_W   = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [PFN_W-1:0] fill_pfn
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]            vld_q;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
    logic [PTR_W-1:0]              ptr_q;
    logic [ENTRIES-1:0]            match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        assign match[e] = vld_q[e] && (tag_q[e] == lk_tag);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[e] <= 1'b0;
                tag_q[e] <= '0;
                pfn_q[e] <= '0;
            end else if (flush) begin
                vld_q[e] <= 1'b0;
            end else if (fill_en && (ptr_q == e[PTR_W-1:0])) begin
                vld_q[e] <= 1'b1;
                tag_q[e] <= fill_tag;
                pfn_q[e] <= fill_pfn;
            end
        end
    end

    always_comb begin
        lk_hit = |match;
        lk_pfn = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) lk_pfn = pfn_q[e];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fill_en && !flush) begin
            ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/dwt_translator.sv
module dwt_translator
    import dwt_pkg::*;
#(
    parameter int NWIN       = 4,
    parameter int ADDR_W     = 32,
    parameter int PA_W       = 40,
    parameter int PTE_W      = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int WIN_LSB    = 20,
    parameter int TLB_N      = 8,
    parameter logic [NWIN*ADDR_W-1:0] DEF_BASE  = RST_BASE,
    parameter logic [NWIN*ADDR_W-1:0] DEF_MASK  = RST_MASK,
    parameter logic [NWIN*PA_W-1:0]   DEF_TBASE = RST_TBASE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [$clog2(NWIN)-1:0] reg_win,
    input  logic [1:0]              reg_kind,
    input  logic [PA_W-1:0]         reg_wdata,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic [PA_W-1:0]         rsp_paddr,
    output logic [1:0]              rsp_err,
    output logic                    rsp_walked,
    output logic                    tbl_req,
    output logic [PA_W-1:0]         tbl_addr,
    input  logic                    tbl_rvalid,
    input  logic [PTE_W-1:0]        tbl_rdata
);

    localparam int WIN_W  = $clog2(NWIN);
    localparam int PG_W   = ADDR_W - PAGE_SHIFT;
    localparam int TAG_W  = WIN_W + PG_W;
    localparam int PFN_W  = PA_W - PAGE_SHIFT;
    localparam int IDX_W  = PG_W + 3;

    dwt_state_e state_q, state_d;

    logic [NWIN-1:0][ADDR_W-1:0] base_w, mask_w;
    logic [NWIN-1:0][PA_W-1:0]   tbase_w;
    logic                        flush;

    logic                        dec_hit, dec_sg;
    logic [WIN_W-1:0]            dec_win;
    logic [ADDR_W-1:0]           dec_off;
    logic [PA_W-1:0]             dec_tbase;

    logic [ADDR_W-1:0]           addr_q;
    logic [TAG_W-1:0]            lk_tag, tag_q;
    logic                        tlb_hit;
    logic [PFN_W-1:0]            tlb_pfn;
    logic                        fill_en;
    logic                        inv_seen_q;
    logic                        pte_ok;

    logic [PA_W-1:0]             paddr_q, tbl_addr_q;
    logic [1:0]                  err_q;
    logic                        walked_q;

    dwt_regs #(
        .NWIN(NWIN), .ADDR_W(ADDR_W), .PA_W(PA_W), .WIN_LSB(WIN_LSB),
        .DEF_BASE(DEF_BASE), .DEF_MASK(DEF_MASK), .DEF_TBASE(DEF_TBASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .win(reg_win),
        .kind(reg_kind), .wdata(reg_wdata),
        .base_o(base_w), .mask_o(mask_w), .tbase_o(tbase_w), .flush_o(flush)
    );

    dwt_decode #(
        .NWIN(NWIN), .ADDR_W(ADDR_W), .PA_W(PA_W), .WIN_LSB(WIN_LSB)
    ) u_dec (
        .addr(addr_q), .base(base_w), .mask(mask_w), .tbase(tbase_w),
        .hit(dec_hit), .win(dec_win), .sg(dec_sg),
        .offset(dec_off), .tbase_sel(dec_tbase)
    );

    assign lk_tag = {dec_win, addr_q[ADDR_W-1:PAGE_SHIFT]};
    assign pte_ok = tbl_rdata[0];

    dwt_tlb #(
        .ENTRIES(TLB_N), .TAG_W(TAG_W), .PFN_W(PFN_W)
    ) u_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_tag(lk_tag), .lk_hit(tlb_hit), .lk_pfn(tlb_pfn),
        .fill_en(fill_en), .fill_tag(tag_q), .fill_pfn(tbl_rdata[PFN_W:1])
    );

    // A flush that lands during or at the end of a table read blocks the fill
    assign fill_en = (state_q == ST_WAIT) && tbl_rvalid && pte_ok &&
                     !inv_seen_q && !flush;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_MATCH;
            ST_MATCH: state_d = (dec_hit && dec_sg && !tlb_hit) ? ST_FETCH : ST_RESP;
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT:  if (tbl_rvalid) state_d = ST_RESP;
            ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rsp_valid  = (state_q == ST_RESP);
        tbl_req    = (state_q == ST_FETCH);
        tbl_addr   = tbl_addr_q;
        rsp_paddr  = paddr_q;
        rsp_err    = err_q;
        rsp_walked = walked_q;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            tag_q      <= '0;
            paddr_q    <= '0;
            tbl_addr_q <= '0;
            err_q      <= ERR_OK;
            walked_q   <= 1'b0;
            inv_seen_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) addr_q <= req_addr;
                end
                ST_MATCH: begin
                    tag_q      <= lk_tag;
                    inv_seen_q <= 1'b0;
                    walked_q   <= 1'b0;
                    tbl_addr_q <= dec_tbase +
                        {{(PA_W-IDX_W){1'b0}}, dec_off[ADDR_W-1:PAGE_SHIFT], 3'b000};
                    if (!dec_hit) begin
                        err_q   <= ERR_NOHIT;
                        paddr_q <= '0;
                    end else if (!dec_sg) begin
                        err_q   <= ERR_OK;
                        paddr_q <= {{(PA_W-ADDR_W){1'b0}}, dec_off};
                    end else if (tlb_hit) begin
                        err_q   <= ERR_OK;
                        paddr_q <= {tlb_pfn, addr_q[PAGE_SHIFT-1:0]};
                    end
                end
                ST_FETCH: begin
                    if (flush) inv_seen_q <= 1'b1;
                end
                ST_WAIT: begin
                    if (flush) inv_seen_q <= 1'b1;
                    if (tbl_rvalid) begin
                        walked_q <= 1'b1;
                        if (pte_ok) begin
                            err_q   <= ERR_OK;
                            paddr_q <= {tbl_rdata[PFN_W:1], addr_q[PAGE_SHIFT-1:0]};
                        end else begin
                            err_q   <= ERR_BADPTE;
                            paddr_q <= '0;
                        end
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dwt_checker.sv
module dwt_checker #(
    parameter int PA_W = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_err,
    input logic            rsp_walked,
    input logic            tbl_req
);

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_err)); // R12

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R12

    AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err == 2'd1 |-> rsp_paddr == '0 && !rsp_walked); // R4

    AST_BADPTE_WALKED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err == 2'd2 |-> rsp_walked && rsp_paddr == '0); // R7

    AST_TBL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_req |=> !tbl_req && !rsp_valid); // R6

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_ready, rsp_valid, tbl_req}) <= 1); // R1

endmodule

bind dwt_translator dwt_checker #(.PA_W(PA_W)) u_dwt_checker (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err),
    .rsp_walked(rsp_walked), .tbl_req(tbl_req)
);

// File: tb/tb_dwt_translator.sv
module tb_dwt_translator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_win = '0;
    logic [1:0]  reg_kind = '0;
    logic [39:0] reg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [39:0] rsp_paddr;
    logic [1:0]  rsp_err;
    logic        rsp_walked;
    logic        tbl_req;
    logic [39:0] tbl_addr;
    logic        tbl_rvalid = 1'b0;
    logic [63:0] tbl_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [31:0] sh_base [4];
    logic [31:0] sh_mask [4];
    logic [39:0] sh_tbase[4];

    always #5 clk = ~clk;

    dwt_translator dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_win(reg_win),
        .reg_kind(reg_kind), .reg_wdata(reg_wdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err),
        .rsp_walked(rsp_walked), .tbl_req(tbl_req), .tbl_addr(tbl_addr),
        .tbl_rvalid(tbl_rvalid), .tbl_rdata(tbl_rdata)
    );

    // Table model: junk above bit 27, frame from the entry address, slot 31 of 32 invalid
    function automatic logic [63:0] pte_of(input logic [39:0] ta);
        logic [63:0] p;
        p = {36'hABC_DE12_3, ta[29:3] ^ 27'h0155AA, 1'b0};
        p[0] = (ta[7:3] != 5'h1F);
        return p;
    endfunction

    task automatic chk(input string req, input logic ok, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int w, input logic [1:0] k, input logic [39:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_win = w[1:0]; reg_kind = k; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (k == 2'd0) sh_base[w] = d[31:0] & 32'hFFF0_0003;
        if (k == 2'd1) sh_mask[w] = d[31:0] & 32'hFFF0_0000;
        if (k == 2'd2) sh_tbase[w] = d;
    endtask

    // Expected result from R2..R7
    task automatic expect_of(input logic [31:0] a, output logic [39:0] pa,
                             output logic [1:0] er, output logic sgw,
                             output logic [39:0] ta);
        logic [31:0] off;
        logic [63:0] p;
        pa = '0; er = 2'd1; sgw = 1'b0; ta = '0;
        for (int w = 3; w >= 0; w--) begin
            if (sh_base[w][0] && ((a[31:20] & ~sh_mask[w][31:20]) == sh_base[w][31:20])) begin
                off = a & {sh_mask[w][31:20], 20'hFFFFF};
                sgw = sh_base[w][1];
                if (!sgw) begin
                    pa = {8'h0, off}; er = 2'd0;
                end else begin
                    ta = sh_tbase[w] + {18'h0, off[31:13], 3'b000};
                    p  = pte_of(ta);
                    if (p[0]) begin pa = {p[27:1], a[12:0]}; er = 2'd0; end
                    else      begin pa = '0; er = 2'd2; end
                end
            end
        end
    endtask

    task automatic lookup(input logic [31:0] a, input logic inv_mid, input logic hold,
                          output logic [39:0] pa, output logic [1:0] er,
                          output logic wk, output logic [39:0] ta_seen);
        int lat = 0;
        logic done = 1'b0;
        ta_seen = '0; pa = '0; er = '0; wk = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        if (hold) rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 200 && !done; n++) begin
            tbl_rvalid = 1'b0;
            reg_we = 1'b0;
            if (rsp_valid) begin
                pa = rsp_paddr; er = rsp_err; wk = rsp_walked; done = 1'b1;
            end else begin
                if (tbl_req) begin
                    ta_seen = tbl_addr; lat = 3;
                    if (inv_mid) begin reg_we = 1'b1; reg_kind = 2'd3; end
                end else if (lat > 0) begin
                    lat--;
                    if (lat == 0) begin tbl_rvalid = 1'b1; tbl_rdata = pte_of(ta_seen); end
                end
                @(negedge clk);
            end
        end
        if (!done) chk("R1 response timeout", 1'b0, 0, 1);
        if (hold && done) begin
            for (int h = 0; h < 3; h++) begin
                @(negedge clk);
                chk("R12 hold", rsp_valid && !req_ready && rsp_paddr == pa && rsp_err == er,
                    {rsp_valid, req_ready, rsp_paddr}, {2'b10, pa});
            end
            rsp_ready = 1'b1;
        end
        @(negedge clk);
        if (hold) chk("R12 release", !rsp_valid && req_ready, {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic run_check(input string req, input logic [31:0] a, input logic inv_mid,
                             input int exp_walk);
        logic [39:0] pa, epa, ta, eta;
        logic [1:0]  er, eer;
        logic        wk, sgw;
        lookup(a, inv_mid, 1'b0, pa, er, wk, ta);
        expect_of(a, epa, eer, sgw, eta);
        chk(req, pa == epa && er == eer, {22'h0, er, pa}, {22'h0, eer, epa});
        if (exp_walk >= 0)
            chk({req, " walked"}, wk == exp_walk[0], wk, exp_walk);
        if (wk) chk({req, " table address R6"}, ta == eta, ta, eta);
    endtask

    initial begin
        logic [31:0] a;
        logic [39:0] pa, ta;
        logic [1:0]  er;
        logic        wk;
        sh_base[0] = 32'h0080_0003; sh_mask[0] = 32'h0070_0000; sh_tbase[0] = 40'h10_0000_0000;
        sh_base[1] = 32'h8000_0001; sh_mask[1] = 32'h3FF0_0000; sh_tbase[1] = 40'h0;
        sh_base[2] = 32'hC000_0003; sh_mask[2] = 32'h3FF0_0000; sh_tbase[2] = 40'h20_0000_0000;
        sh_base[3] = 32'h0;         sh_mask[3] = 32'h0;         sh_tbase[3] = 40'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", req_ready && !rsp_valid && !tbl_req,
            {req_ready, rsp_valid, tbl_req}, 3'b100);

        // R1 R2 R4 R5 R6 R7: sweep every 1 MB granule against the reset windows
        for (int i = 0; i < 4096; i++) begin
            a = {i[11:0], 20'h0} | ((i * 32'h0002468B) & 32'h000F_FFFF);
            run_check("R1/R5/R6 sweep", a, 1'b0,
                      (sh_base[0][0] && a[31:23] == 9'h001) || a[31:30] == 2'b11 ? 1 : 0);
        end

        // R8: repeat page hits the cache
        wr_reg(0, 2'd3, 40'h0);
        run_check("R8 first", 32'hC000_4010, 1'b0, 1);
        run_check("R8 repeat", 32'hC000_4010, 1'b0, 0);
        run_check("R8 same page", 32'hC000_5FF8, 1'b0, 0);

        // R9: round-robin eviction
        wr_reg(0, 2'd3, 40'h0);
        for (int k = 0; k < 9; k++)
            run_check("R9 fill", 32'hC000_0000 + k * 32'h2000, 1'b0, 1);
        run_check("R9 evicted", 32'hC000_0000, 1'b0, 1);
        run_check("R9 kept", 32'hC000_4000, 1'b0, 0);
        run_check("R9 newest", 32'hC001_0000, 1'b0, 0);

        // R10: invalidate all
        wr_reg(0, 2'd3, 40'h0);
        run_check("R10 after flush", 32'hC001_0000, 1'b0, 1);

        // R11: flush during a table read
        wr_reg(0, 2'd3, 40'h0);
        run_check("R11 mid flush", 32'hC000_6000, 1'b1, 1);
        run_check("R11 not cached", 32'hC000_6000, 1'b0, 1);

        // R7: invalid entry not cached
        run_check("R7 bad pte", 32'hC003_E123, 1'b0, 1);
        run_check("R7 bad pte again", 32'hC003_E123, 1'b0, 1);

        // R12: backpressure
        lookup(32'h8765_4321, 1'b0, 1'b1, pa, er, wk, ta);
        chk("R12 value", pa == 40'h07_6543_21 && er == 2'd0, pa, 40'h0765_4321);

        // R2: disable window 1
        wr_reg(1, 2'd0, 40'h8000_0000);
        run_check("R2 disabled", 32'h9000_0000, 1'b0, 0);
        // R3: overlapping direct window 3, window 2 wins
        wr_reg(3, 2'd1, 40'h0FF0_0000);
        wr_reg(3, 2'd0, 40'hC000_0001);
        wr_reg(0, 2'd3, 40'h0);
        run_check("R3 priority", 32'hC123_4567, 1'b0, 1);
        wr_reg(2, 2'd0, 40'h0);
        run_check("R3 fallback", 32'hC123_4567, 1'b0, 0);
        chk("R3 shadow", sh_base[2] == 0, sh_base[2], 0);
        run_check("R4 outside", 32'hD000_0000, 1'b0, 0);
        // R6: moved table base
        wr_reg(0, 2'd2, 40'h00_0200_0000);
        wr_reg(0, 2'd3, 40'h0);
        run_check("R6 new tbase", 32'h0085_A0F0, 1'b0, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule